// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Access

This peripheral is a small SPI bus master that a processor drives through two 32-bit registers on a simple bus. Every access to either register takes one cycle. Software first places the outgoing byte in the data register. It then writes the control register with the start bit set, and with the chip-select levels, the clock divider and the loopback choice it wants. The block shifts one byte out on MOSI and one byte in at the same time. It then leaves the received byte in the data register for software to read back.

The serial clock comes from the reference clock through a programmable divider. The control word's top five bits hold a value N, and each half of an SCK period lasts N+1 reference cycles. The transfer uses SPI mode 0 with the most significant bit first: SCK rests low, MOSI moves on falling edges, and the input is sampled on rising edges. The three chip-select outputs are plain software-controlled levels taken from even control bits. Loopback routes MOSI back into the receiver, so the bus can be tested without a slave.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, the three chip-select pins are high and SCK and MOSI are low. A control read returns 0x0000_0015 and a data read returns 0.
- R2: A control write (byte offset 0x0) with bit 1 set, made while idle, starts one 8-bit transfer. Control bit 1 then reads 1 from the next cycle until the transfer ends. A control write with bit 1 clear starts nothing.
- R3: Chip-select pin n (n = 0, 1, 2) takes the value of control bit 2n in the cycle after every control write. This holds for writes made while a transfer is running.
- R4: When control bit 3 is 1, the receiver takes its input from MOSI and the MISO pin has no effect. The received byte then equals the byte sent.
- R5: Control bits 31:27 hold N. Each SCK high phase and each SCK low phase within a transfer lasts N+1 reference cycles.
- R6: The transfer runs in SPI mode 0, MSB first. SCK is low whenever the block is idle. MOSI changes only at the start and on SCK falling edges. MISO is sampled on SCK rising edges.
- R7: A transfer holds busy for exactly 16·(N+1) reference cycles. Busy clears in the same cycle in which SCK makes its eighth falling edge.
- R8: A data write (byte offset 0x4) made while idle stores bits 7:0 as the byte to send. At the end of a transfer the data register holds the received byte. Data reads return that byte in bits 7:0 and zeros in bits 31:8.
- R9: While busy, a control write with bit 1 set does not restart or lengthen the transfer, and a data write is ignored.
- R10: A control read returns chip selects on bits 0, 2 and 4, busy on bit 1, loopback on bit 3, N on bits 31:27, and zeros in all other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset (0x0 control, 0x4 data) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_lvl | output | 3 | Chip-select levels, one per select line |

## Verification
A wrong divider count or a wrong edge counter shows within one transfer. Busy lasts longer or shorter than 16·(N+1) cycles, and the byte the slave model captures from MOSI, or the byte read back from the data register, comes out shifted or truncated. A faulty busy gate or a faulty write qualifier shows in the cycle after the offending write: the chip-select pins do not match the written bits, a restart stretches the busy window, or a data read during the transfer returns the ignored byte. A broken loopback select gives a received byte that equals the inverted pattern on MISO rather than the transmitted byte.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

   // control word bit positions that software and the shifter both depend on
   localparam int CTRL_START_POS = 1;
   localparam int CTRL_LOOP_POS  = 3;

   // word index (byte offset / 4) of each register
   localparam int WORD_CTRL = 0;
   localparam int WORD_DATA = 1;

   typedef enum logic {
      XS_IDLE = 1'b0,
      XS_RUN  = 1'b1
   } xfer_state_e;

endpackage

// File: rtl/spi_bm_regs.sv
module spi_bm_regs
   import spi_bm_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 3,
   parameter int NUM_CS    = 3,
   parameter int DIV_W     = 5,
   parameter int XFER_BITS = 8,
   parameter int DIV_RESET = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel,
   input  logic                 we,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   input  logic                 busy,
   input  logic                 done,
   input  logic [XFER_BITS-1:0] rx_byte,
   output logic [NUM_CS-1:0]    cs_lvl,
   output logic [DIV_W-1:0]     div,
   output logic                 loop_en,
   output logic                 start,
   output logic [XFER_BITS-1:0] tx_byte
);

   localparam int WORD_W = ADDR_W - 2;
   localparam int DIV_LO = DATA_W - DIV_W;

   generate
      if (WORD_W < 1) begin : g_bad_addr
         $error("spi_bm_regs: ADDR_W must be at least 3");
      end
      if (2 * NUM_CS - 1 >= DIV_LO) begin : g_bad_cs
         $error("spi_bm_regs: chip-select bits overlap the divider field");
      end
      if (XFER_BITS > DATA_W || XFER_BITS < 2) begin : g_bad_bits
         $error("spi_bm_regs: XFER_BITS out of range");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic              hit_ctrl;
   logic              hit_data;
   logic              wr_ctrl;
   logic              wr_data;

   assign word     = addr[ADDR_W-1:2];
   assign hit_ctrl = sel && (word == WORD_W'(WORD_CTRL));
   assign hit_data = sel && (word == WORD_W'(WORD_DATA));
   assign wr_ctrl  = hit_ctrl && we;
   assign wr_data  = hit_data && we;
   assign start    = wr_ctrl && wdata[CTRL_START_POS] && !busy;

   // chip-select levels: one flop per line, sourced from even control bits
   logic [NUM_CS-1:0] cs_q;
   genvar gi;
   generate
      for (gi = 0; gi < NUM_CS; gi++) begin : g_cs
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cs_q[gi] <= 1'b1;
            end else if (wr_ctrl) begin
               cs_q[gi] <= wdata[2*gi];
            end
         end
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic             loop_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= DIV_W'(DIV_RESET);
         loop_q <= 1'b0;
      end else if (wr_ctrl) begin
         div_q  <= wdata[DATA_W-1:DIV_LO];
         loop_q <= wdata[CTRL_LOOP_POS];
      end
   end

   // one byte of storage: outgoing byte before a transfer, received byte after
   logic [XFER_BITS-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (done) begin
         data_q <= rx_byte;
      end else if (wr_data && !busy) begin
         data_q <= wdata[XFER_BITS-1:0];
      end
   end

   logic [DATA_W-1:0] ctrl_view;

   always_comb begin
      ctrl_view = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         ctrl_view[2*i] = cs_q[i];
      end
      ctrl_view[CTRL_START_POS]      = busy;
      ctrl_view[CTRL_LOOP_POS]       = loop_q;
      ctrl_view[DATA_W-1:DIV_LO]     = div_q;
   end

   always_comb begin
      if (hit_ctrl && !we) begin
         rdata = ctrl_view;
      end else if (hit_data && !we) begin
         rdata = {{(DATA_W-XFER_BITS){1'b0}}, data_q};
      end else begin
         rdata = '0;
      end
   end

   assign cs_lvl  = cs_q;
   assign div     = div_q;
   assign loop_en = loop_q;
   assign tx_byte = data_q;

endmodule

// File: rtl/spi_bm_clkdiv.sv
module spi_bm_clkdiv #(
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("spi_bm_clkdiv: DIV_W must be positive");
      end
   endgenerate

   logic [DIV_W-1:0] cnt_q;

   // tick marks the last reference cycle of an SCK half period
   assign tick = run && (cnt_q == div);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || tick) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/spi_bm_shifter.sv
module spi_bm_shifter
   import spi_bm_pkg::*;
#(
   parameter int XFER_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [XFER_BITS-1:0] tx_byte,
   input  logic                 tick,
   input  logic                 loop_en,
   input  logic                 miso,
   output logic                 sck,
   output logic                 mosi,
   output logic                 busy,
   output logic                 done,
   output logic [XFER_BITS-1:0] rx_byte
);

   localparam int EDGES = 2 * XFER_BITS;
   localparam int EC_W  = $clog2(EDGES);
   localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(EDGES - 1);

   xfer_state_e          state_q;
   logic                 sck_q;
   logic [EC_W-1:0]      edge_q;
   logic [XFER_BITS-1:0] tx_sh;
   logic [XFER_BITS-1:0] rx_sh;
   logic                 rx_in;

   assign rx_in = loop_en ? tx_sh[XFER_BITS-1] : miso;
   assign done  = (state_q == XS_RUN) && tick && sck_q && (edge_q == LAST_EDGE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         sck_q   <= 1'b0;
         edge_q  <= '0;
         tx_sh   <= '0;
         rx_sh   <= '0;
      end else begin
         case (state_q)
            XS_IDLE: begin
               if (start) begin
                  state_q <= XS_RUN;
                  sck_q   <= 1'b0;
                  edge_q  <= '0;
                  tx_sh   <= tx_byte;
                  rx_sh   <= '0;
               end
            end
            XS_RUN: begin
               if (tick) begin
                  edge_q <= edge_q + EC_W'(1);
                  if (!sck_q) begin
                     sck_q <= 1'b1;
                     rx_sh <= {rx_sh[XFER_BITS-2:0], rx_in};
                  end else begin
                     sck_q <= 1'b0;
                     tx_sh <= {tx_sh[XFER_BITS-2:0], 1'b0};
                     if (edge_q == LAST_EDGE) begin
                        state_q <= XS_IDLE;
                     end
                  end
               end
            end
            default: state_q <= XS_IDLE;
         endcase
      end
   end

   assign sck     = sck_q;
   assign mosi    = tx_sh[XFER_BITS-1];
   assign busy    = (state_q == XS_RUN);
   assign rx_byte = rx_sh;

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 3,
   parameter int NUM_CS    = 3,
   parameter int DIV_W     = 5,
   parameter int XFER_BITS = 8,
   parameter int DIV_RESET = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NUM_CS-1:0] spi_cs_lvl
);

   generate
      if (DIV_RESET >= (1 << DIV_W)) begin : g_bad_reset_div
         $error("spi_byte_master: DIV_RESET does not fit in DIV_W bits");
      end
   endgenerate

   logic                 busy_w;
   logic                 done_w;
   logic                 start_w;
   logic                 tick_w;
   logic                 loop_w;
   logic [DIV_W-1:0]     div_w;
   logic [XFER_BITS-1:0] tx_w;
   logic [XFER_BITS-1:0] rx_w;

   spi_bm_regs #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .NUM_CS    (NUM_CS),
      .DIV_W     (DIV_W),
      .XFER_BITS (XFER_BITS),
      .DIV_RESET (DIV_RESET)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (bus_sel),
      .we      (bus_we),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .rdata   (bus_rdata),
      .busy    (busy_w),
      .done    (done_w),
      .rx_byte (rx_w),
      .cs_lvl  (spi_cs_lvl),
      .div     (div_w),
      .loop_en (loop_w),
      .start   (start_w),
      .tx_byte (tx_w)
   );

   spi_bm_clkdiv #(
      .DIV_W (DIV_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy_w),
      .restart (start_w),
      .div     (div_w),
      .tick    (tick_w)
   );

   spi_bm_shifter #(
      .XFER_BITS (XFER_BITS)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_w),
      .tx_byte (tx_w),
      .tick    (tick_w),
      .loop_en (loop_w),
      .miso    (spi_miso),
      .sck     (spi_sck),
      .mosi    (spi_mosi),
      .busy    (busy_w),
      .done    (done_w),
      .rx_byte (rx_w)
   );

endmodule

// File: rtl/spi_bm_checker.sv
module spi_bm_checker #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 3,
   parameter int NUM_CS    = 3,
   parameter int DIV_W     = 5,
   parameter int XFER_BITS = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              spi_sck,
   input logic              spi_mosi,
   input logic [NUM_CS-1:0] spi_cs_lvl,
   input logic              busy
);

   localparam int DIV_LO = DATA_W - DIV_W;

   logic ctrl_wr;
   logic data_rd;
   logic start_req;
   logic [NUM_CS-1:0] cs_want;

   assign ctrl_wr   = bus_sel && bus_we && (bus_addr[ADDR_W-1:2] == '0);
   assign data_rd   = bus_sel && !bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
   assign start_req = ctrl_wr && bus_wdata[1];

   always_comb begin
      for (int i = 0; i < NUM_CS; i++) begin
         cs_want[i] = bus_wdata[2*i];
      end
   end

   // half-period length tracker
   logic             sck_d;
   logic             tracking;
   logic [DIV_W:0]   run_len;
   logic [DIV_W-1:0] div_cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sck_d    <= 1'b0;
         tracking <= 1'b0;
         run_len  <= '0;
         div_cap  <= '0;
      end else begin
         sck_d <= spi_sck;
         if (start_req && !busy) begin
            tracking <= 1'b1;
            run_len  <= '0;
            div_cap  <= bus_wdata[DATA_W-1:DIV_LO];
         end else if (spi_sck != sck_d) begin
            run_len <= (DIV_W+1)'(1);
         end else begin
            run_len <= run_len + (DIV_W+1)'(1);
         end
      end
   end

   a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start_req && !busy) |=> busy);

   a_r3_cs_follow: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (spi_cs_lvl == $past(cs_want)));

   a_r5_half_period: assert property (@(posedge clk) disable iff (!rst_n)
      (tracking && (spi_sck != sck_d)) |-> (run_len == {1'b0, div_cap} + (DIV_W+1)'(1)));

   a_r6_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !spi_sck);

   a_r6_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$fell(spi_sck)) |-> $stable(spi_mosi));

   a_r7_end_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !spi_sck);

   a_r8_rdata_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd |-> (bus_rdata[DATA_W-1:XFER_BITS] == '0));

endmodule

bind spi_byte_master spi_bm_checker #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .NUM_CS    (NUM_CS),
   .DIV_W     (DIV_W),
   .XFER_BITS (XFER_BITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .spi_sck    (spi_sck),
   .spi_mosi   (spi_mosi),
   .spi_cs_lvl (spi_cs_lvl),
   .busy       (busy_w)
);

// File: tb/sim_spi_byte_master.sv
`timescale 1ns/1ps
module sim_spi_byte_master;

   localparam real HALF = 2.5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        spi_sck;
   logic        spi_mosi;
   logic        spi_miso;
   logic [2:0]  spi_cs_lvl;

   always #(HALF) clk = ~clk;

   spi_byte_master u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .spi_sck    (spi_sck),
      .spi_mosi   (spi_mosi),
      .spi_miso   (spi_miso),
      .spi_cs_lvl (spi_cs_lvl)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // slave model: drives MISO MSB first, moving on SCK falling edges; captures MOSI on rising edges
   logic [7:0] slv_sh = '0;
   logic [7:0] mosi_cap = '0;
   assign spi_miso = slv_sh[7];
   always @(negedge spi_sck) slv_sh <= {slv_sh[6:0], 1'b0};
   always @(posedge spi_sck) mosi_cap <= {mosi_cap[6:0], spi_mosi};

   typedef struct packed {
      logic [4:0] div;
      logic       loop;
      logic [7:0] tx;
      logic [7:0] pat;
      logic [2:0] cs;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{div: 5'd0,  loop: 1'b0, tx: 8'hA5, pat: 8'h3C, cs: 3'b110},
      '{div: 5'd1,  loop: 1'b0, tx: 8'h01, pat: 8'h80, cs: 3'b101},
      '{div: 5'd3,  loop: 1'b0, tx: 8'hFF, pat: 8'h00, cs: 3'b011},
      '{div: 5'd0,  loop: 1'b1, tx: 8'h5A, pat: 8'hA5, cs: 3'b111},
      '{div: 5'd7,  loop: 1'b1, tx: 8'hC3, pat: 8'h3C, cs: 3'b000},
      '{div: 5'd31, loop: 1'b0, tx: 8'h00, pat: 8'hFF, cs: 3'b010}
   };

   function automatic logic [31:0] ctl(input logic [4:0] d, input logic lp,
                                       input logic [2:0] cs, input logic go);
      logic [31:0] w;
      w = '0;
      w[31:27] = d;
      w[4] = cs[2];
      w[3] = lp;
      w[2] = cs[1];
      w[1] = go;
      w[0] = cs[0];
      return w;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic wait_idle(input int t0, output int dur, output logic sck_at_end);
      logic [31:0] r;
      do begin
         rd(3'h0, r);
      end while (r[1] === 1'b1);
      dur = cyc - t0;
      sck_at_end = spi_sck;
   endtask

   task automatic summary;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] r;
      int t0;
      int dur;
      logic sck_end;
      logic [7:0] exp_rx;

      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(3'h0, r);
      chk("R1 ctrl after reset", r, 32'h0000_0015);
      rd(3'h4, r);
      chk("R1 data after reset", r, 32'h0);
      chk("R1 cs pins after reset", {29'b0, spi_cs_lvl}, 32'h7);
      chk("R1 sck/mosi after reset", {30'b0, spi_sck, spi_mosi}, 32'h0);

      // vector table walk
      foreach (VECS[i]) begin
         wr(3'h4, {24'h0, VECS[i].tx});
         slv_sh = VECS[i].loop ? ~VECS[i].tx : VECS[i].pat;
         mosi_cap = '0;
         exp_rx = VECS[i].loop ? VECS[i].tx : VECS[i].pat;
         wr(3'h0, ctl(VECS[i].div, VECS[i].loop, VECS[i].cs, 1'b1));
         t0 = cyc;
         chk($sformatf("R3 cs pins vec%0d", i), {29'b0, spi_cs_lvl}, {29'b0, VECS[i].cs});
         wait_idle(t0, dur, sck_end);
         chk($sformatf("R7 R5 busy length vec%0d", i), dur, 16 * (VECS[i].div + 1));
         chk($sformatf("R6 sck low at end vec%0d", i), {31'b0, sck_end}, 32'h0);
         rd(3'h4, r);
         chk($sformatf("%s rx byte vec%0d", VECS[i].loop ? "R4" : "R8", i), r, {24'h0, exp_rx});
         chk($sformatf("R6 mosi msb first vec%0d", i), {24'h0, mosi_cap}, {24'h0, VECS[i].tx});
      end

      // R10 control readback layout, and R2 no start when bit 1 clear
      wr(3'h0, ctl(5'd21, 1'b1, 3'b101, 1'b0) | 32'h07FF_FFE0);
      rd(3'h0, r);
      chk("R10 R2 ctrl readback", r, ctl(5'd21, 1'b1, 3'b101, 1'b0));

      // R8 data write while idle, upper bits read as zero
      wr(3'h4, 32'hFFFF_FFA5);
      rd(3'h4, r);
      chk("R8 data readback", r, 32'h0000_00A5);

      // R9 writes during a running transfer, R3 cs update while busy
      wr(3'h4, 32'h0000_0096);
      slv_sh = 8'h69;
      mosi_cap = '0;
      wr(3'h0, ctl(5'd3, 1'b0, 3'b111, 1'b1));
      t0 = cyc;
      rd(3'h0, r);
      chk("R2 busy reads 1", {31'b0, r[1]}, 32'h1);
      repeat (8) @(negedge clk);
      wr(3'h0, ctl(5'd3, 1'b0, 3'b010, 1'b1));
      chk("R3 cs update while busy", {29'b0, spi_cs_lvl}, 32'h2);
      wr(3'h4, 32'h0000_0011);
      rd(3'h4, r);
      chk("R9 data write ignored while busy", r, 32'h0000_0096);
      wait_idle(t0, dur, sck_end);
      chk("R9 restart ignored, length", dur, 64);
      rd(3'h4, r);
      chk("R9 rx after ignored writes", r, 32'h0000_0069);
      chk("R9 original byte sent", {24'h0, mosi_cap}, 32'h0000_0096);

      summary();
      $finish;
   end

endmodule